// File: doc/BRIEF.md
# General-Purpose I/O Port

This block is one small I/O port of a microcontroller. It serves four pin positions. Positions 3, 1 and 0 are general bidirectional pins. Position 2 is a fixed output that passes an externally modulated LED drive signal straight to its pad. For each position the block produces three pad controls: an output value, an output enable and a pull-up enable. It also takes in the raw levels seen at the pads.

Software reaches the port through a plain register bus with an address, a write strobe, write data and combinational read data. Three addresses matter:

- **Direction register.** Chooses, per general pin, whether the pin drives or listens.
- **Data latch.** Holds the value a driving pin puts out. When the pin is an input, the same latch bit switches the pin's pull-up on.
- **Pin-level address.** Read-only. It returns the synchronized logic levels present on the pins, not the latch.

An asynchronous reset clears the direction and latch bits at once. This tri-states every general pin and drops every pull-up, even while the clock is stopped.

Top module: `gpio_port`

## Requirements
- R1: A general pin (bit 3, 1 or 0) whose direction bit is 1 has its output enable high, its pull-up low, and drives its latch bit as the output value.
- R2: A general pin with direction bit 0 and latch bit 0 has output enable low and pull-up low (high impedance).
- R3: A general pin with direction bit 0 and latch bit 1 has output enable low and pull-up high.
- R4: While reset (rst_n = 0) is active, the direction and latch bits are cleared without any clock edge. All general pins then show output enable 0 and pull-up 0.
- R5: A write to the direction address 0x1A or the data address 0x1B takes effect on the next clock edge. Reading either address returns the stored bits at positions 3, 1 and 0, and 0 at bits 7 to 4 and at bit 2 (bit 2 is never stored).
- R6: Reading the pin-level address 0x19 returns the pad levels of bits 3, 1 and 0 through a two-flop synchronizer. A pad change therefore shows two clock edges later. Bits 7 to 4 and bit 2 read 0. The result is independent of the latch.
- R7: A write to 0x19 changes neither the direction bits nor the latch bits.
- R8: Bit position 2 always has output enable 1 and pull-up 0, and its output value equals led_mod. The direction register has no effect on it.
- R9: Writes to any address other than 0x1A and 0x1B change no state.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus and synchronizer clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 8 | Register address |
| bus_wr_en | input | 1 | Write strobe, sampled on the rising clock edge |
| bus_wr_data | input | 8 | Write data |
| bus_rd_data | output | 8 | Read data for bus_addr, combinational |
| led_mod | input | 1 | Modulated LED drive for bit position 2 |
| pin_in | input | 4 | Raw pad levels |
| pin_out | output | 4 | Per-position output value |
| pin_oe | output | 4 | Per-position output enable |
| pin_pu | output | 4 | Per-position pull-up enable |

## Verification
Each result has its own latency, and every sample is taken on a falling edge:

- **Writes.** A write strobed before a rising edge changes the pad controls and the register read-back right after that edge. The bench therefore samples them on the falling edge that follows the write cycle.
- **Pin levels.** The pin-level read is sampled twice: once a single edge after a pad change, where the old value is expected, and once after the second edge, where the new value must appear.
- **Reset.** It is checked a few nanoseconds after rst_n falls with the clock held still. No edge is involved, so the pad controls must already be tri-stated.
- **LED position.** Bit 2 is purely combinational and is sampled right after led_mod changes.

// File: rtl/gpio_port_pkg.sv
package gpio_port_pkg;

    // Decoded register selection on the bus
    typedef enum logic [1:0] {
        SEL_NONE,
        SEL_DIR,
        SEL_DATA,
        SEL_PIN
    } reg_sel_e;

    function automatic reg_sel_e decode_sel(
        input logic [7:0] addr,
        input logic [7:0] a_dir,
        input logic [7:0] a_data,
        input logic [7:0] a_pin
    );
        reg_sel_e s;
        if (addr == a_dir)       s = SEL_DIR;
        else if (addr == a_data) s = SEL_DATA;
        else if (addr == a_pin)  s = SEL_PIN;
        else                     s = SEL_NONE;
        return s;
    endfunction

endpackage

// File: rtl/gpio_port_sync.sv
module gpio_port_sync #(
    parameter int NPIN   = 4,
    parameter int STAGES = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NPIN-1:0] din,
    output logic [NPIN-1:0] dout
);
    logic [STAGES-1:0][NPIN-1:0] sync_d, sync_q;

    always_comb begin
        sync_d[0] = din;
        for (int i = 1; i < STAGES; i++) begin
            sync_d[i] = sync_q[i-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sync_q <= '0;
        else        sync_q <= sync_d;
    end

    assign dout = sync_q[STAGES-1];
endmodule

// File: rtl/gpio_port_regs.sv
module gpio_port_regs
    import gpio_port_pkg::*;
#(
    parameter int          NPIN      = 4,
    parameter int          DW        = 8,
    parameter logic [7:0]  ADDR_PIN  = 8'h19,
    parameter logic [7:0]  ADDR_DIR  = 8'h1A,
    parameter logic [7:0]  ADDR_DATA = 8'h1B,
    parameter logic [NPIN-1:0] GEN_MASK = 4'b1011
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [7:0]      addr,
    input  logic            wr_en,
    input  logic [DW-1:0]   wr_data,
    input  logic [NPIN-1:0] pin_lvl,
    output logic [NPIN-1:0] dir_q,
    output logic [NPIN-1:0] lat_q,
    output logic [DW-1:0]   rd_data
);
    localparam int PAD_W = DW - NPIN;

    typedef struct packed {
        logic [NPIN-1:0] dir;
        logic [NPIN-1:0] lat;
    } regs_t;

    regs_t    r_d, r_q;
    reg_sel_e sel;
    logic [NPIN-1:0] rd_field;
    logic     unused_wr_hi;

    assign sel          = decode_sel(addr, ADDR_DIR, ADDR_DATA, ADDR_PIN);
    assign unused_wr_hi = ^wr_data[DW-1:NPIN];

    always_comb begin
        r_d = r_q;
        if (wr_en) begin
            case (sel)
                SEL_DIR:  r_d.dir = wr_data[NPIN-1:0] & GEN_MASK;
                SEL_DATA: r_d.lat = wr_data[NPIN-1:0] & GEN_MASK;
                default:  r_d     = r_q;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    always_comb begin
        case (sel)
            SEL_DIR:  rd_field = r_q.dir;
            SEL_DATA: rd_field = r_q.lat;
            SEL_PIN:  rd_field = pin_lvl & GEN_MASK;
            default:  rd_field = '0;
        endcase
    end

    assign rd_data = {{PAD_W{1'b0}}, rd_field};
    assign dir_q   = r_q.dir;
    assign lat_q   = r_q.lat;
endmodule

// File: rtl/gpio_port_pad.sv
module gpio_port_pad #(
    parameter int NPIN    = 4,
    parameter int LED_POS = 2
) (
    input  logic [NPIN-1:0] dir_q,
    input  logic [NPIN-1:0] lat_q,
    input  logic            led_mod,
    output logic [NPIN-1:0] pin_out,
    output logic [NPIN-1:0] pin_oe,
    output logic [NPIN-1:0] pin_pu
);
    logic unused_led_regs;
    assign unused_led_regs = dir_q[LED_POS] ^ lat_q[LED_POS];

    for (genvar b = 0; b < NPIN; b++) begin : g_pin
        if (b == LED_POS) begin : g_led
            assign pin_out[b] = led_mod;
            assign pin_oe[b]  = 1'b1;
            assign pin_pu[b]  = 1'b0;
        end else begin : g_gen
            assign pin_out[b] = lat_q[b];
            assign pin_oe[b]  = dir_q[b];
            assign pin_pu[b]  = ~dir_q[b] & lat_q[b];
        end
    end
endmodule

// File: rtl/gpio_port.sv
module gpio_port #(
    parameter int         NPIN        = 4,
    parameter int         DW          = 8,
    parameter int         LED_POS     = 2,
    parameter int         SYNC_STAGES = 2,
    parameter logic [7:0] ADDR_PIN    = 8'h19,
    parameter logic [7:0] ADDR_DIR    = 8'h1A,
    parameter logic [7:0] ADDR_DATA   = 8'h1B
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [7:0]      bus_addr,
    input  logic            bus_wr_en,
    input  logic [DW-1:0]   bus_wr_data,
    output logic [DW-1:0]   bus_rd_data,
    input  logic            led_mod,
    input  logic [NPIN-1:0] pin_in,
    output logic [NPIN-1:0] pin_out,
    output logic [NPIN-1:0] pin_oe,
    output logic [NPIN-1:0] pin_pu
);
    localparam logic [NPIN-1:0] GEN_MASK = ~(NPIN'(1) << LED_POS);

    logic [NPIN-1:0] dir_q, lat_q, pin_lvl;

    gpio_port_sync #(.NPIN(NPIN), .STAGES(SYNC_STAGES)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .din  (pin_in),
        .dout (pin_lvl)
    );

    gpio_port_regs #(
        .NPIN(NPIN), .DW(DW), .ADDR_PIN(ADDR_PIN), .ADDR_DIR(ADDR_DIR),
        .ADDR_DATA(ADDR_DATA), .GEN_MASK(GEN_MASK)
    ) u_regs (
        .clk    (clk),
        .rst_n  (rst_n),
        .addr   (bus_addr),
        .wr_en  (bus_wr_en),
        .wr_data(bus_wr_data),
        .pin_lvl(pin_lvl),
        .dir_q  (dir_q),
        .lat_q  (lat_q),
        .rd_data(bus_rd_data)
    );

    gpio_port_pad #(.NPIN(NPIN), .LED_POS(LED_POS)) u_pad (
        .dir_q  (dir_q),
        .lat_q  (lat_q),
        .led_mod(led_mod),
        .pin_out(pin_out),
        .pin_oe (pin_oe),
        .pin_pu (pin_pu)
    );
endmodule

// File: rtl/gpio_port_chk.sv
module gpio_port_chk #(
    parameter int         NPIN        = 4,
    parameter int         DW          = 8,
    parameter int         LED_POS     = 2,
    parameter int         SYNC_STAGES = 2,
    parameter logic [7:0] ADDR_PIN    = 8'h19
) (
    input logic            clk,
    input logic            rst_n,
    input logic [7:0]      bus_addr,
    input logic            bus_wr_en,
    input logic [DW-1:0]   bus_rd_data,
    input logic            led_mod,
    input logic [NPIN-1:0] pin_in,
    input logic [NPIN-1:0] pin_out,
    input logic [NPIN-1:0] pin_oe,
    input logic [NPIN-1:0] pin_pu,
    input logic [NPIN-1:0] dir_q,
    input logic [NPIN-1:0] lat_q,
    input logic [NPIN-1:0] pin_lvl
);
    localparam logic [NPIN-1:0] GEN = ~(NPIN'(1) << LED_POS);

    logic [1:0] age;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)         age <= '0;
        else if (age != 2'd3) age <= age + 2'd1;
    end

    a_r1_drive: assert property (@(posedge clk) disable iff (!rst_n)
        ((pin_oe & dir_q) == dir_q) && (((pin_out ^ lat_q) & dir_q) == '0)
        && ((pin_pu & dir_q) == '0));

    a_r2_hiz: assert property (@(posedge clk) disable iff (!rst_n)
        ((~dir_q & ~lat_q & GEN & (pin_oe | pin_pu)) == '0));

    a_r3_pullup: assert property (@(posedge clk) disable iff (!rst_n)
        ((~dir_q & lat_q & GEN & ~pin_pu) == '0) && ((~dir_q & GEN & pin_oe) == '0));

    a_r4_reset_tristate: assert property (@(posedge clk)
        !rst_n |-> (((pin_oe & GEN) == '0) && (pin_pu == '0)));

    a_r6_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr == ADDR_PIN) |-> ((bus_rd_data[DW-1:NPIN] == '0) && !bus_rd_data[LED_POS]));

    if (SYNC_STAGES == 2) begin : g_lag
        a_r6_two_flop_lag: assert property (@(posedge clk) disable iff (!rst_n)
            (age >= 2'd2) |-> (pin_lvl == $past(pin_in, 2)));
    end

    a_r7_pin_write_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr_en && bus_addr == ADDR_PIN) |=> ($stable(dir_q) && $stable(lat_q)));

    a_r8_led_fixed: assert property (@(posedge clk) disable iff (!rst_n)
        pin_oe[LED_POS] && !pin_pu[LED_POS] && (pin_out[LED_POS] == led_mod));
endmodule

bind gpio_port gpio_port_chk #(
    .NPIN(NPIN), .DW(DW), .LED_POS(LED_POS), .SYNC_STAGES(SYNC_STAGES), .ADDR_PIN(ADDR_PIN)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .bus_addr   (bus_addr),
    .bus_wr_en  (bus_wr_en),
    .bus_rd_data(bus_rd_data),
    .led_mod    (led_mod),
    .pin_in     (pin_in),
    .pin_out    (pin_out),
    .pin_oe     (pin_oe),
    .pin_pu     (pin_pu),
    .dir_q      (dir_q),
    .lat_q      (lat_q),
    .pin_lvl    (pin_lvl)
);

// File: tb/gpio_port_tb.sv
`timescale 1ns/1ps
module gpio_port_tb;
    localparam logic [7:0] A_PIN  = 8'h19;
    localparam logic [7:0] A_DIR  = 8'h1A;
    localparam logic [7:0] A_DATA = 8'h1B;

    logic       clk = 1'b0;
    logic       clk_run = 1'b1;
    logic       rst_n = 1'b0;
    logic [7:0] bus_addr = '0;
    logic       bus_wr_en = 1'b0;
    logic [7:0] bus_wr_data = '0;
    logic [7:0] bus_rd_data;
    logic       led_mod = 1'b1;
    logic [3:0] pin_in = '0;
    logic [3:0] pin_out, pin_oe, pin_pu;

    int checks = 0;
    int fails  = 0;

    always #2 if (clk_run) clk = ~clk;

    gpio_port u_dut (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr_en(bus_wr_en),
        .bus_wr_data(bus_wr_data), .bus_rd_data(bus_rd_data), .led_mod(led_mod),
        .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe), .pin_pu(pin_pu)
    );

    // {dir written, latch written, expected oe, expected pu, expected driven out}
    localparam logic [19:0] VEC [8] = '{
        {4'b0000, 4'b0000, 4'b0100, 4'b0000, 4'b0000},
        {4'b0000, 4'b1011, 4'b0100, 4'b1011, 4'b0000},
        {4'b1011, 4'b0000, 4'b1111, 4'b0000, 4'b0000},
        {4'b1011, 4'b1011, 4'b1111, 4'b0000, 4'b1011},
        {4'b1000, 4'b1001, 4'b1100, 4'b0001, 4'b1000},
        {4'b0011, 4'b1010, 4'b0111, 4'b1000, 4'b0010},
        {4'b0001, 4'b0010, 4'b0101, 4'b0010, 4'b0000},
        {4'b1111, 4'b0100, 4'b1111, 4'b0000, 4'b0000}
    };

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_wr_data = d; bus_wr_en = 1'b1;
        @(negedge clk);
        bus_wr_en = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [7:0] d);
        bus_addr = a;
        #0.5;
        d = bus_rd_data;
    endtask

    task automatic summary;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    endtask

    initial begin
        #400000;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
        $finish;
    end

    initial begin
        logic [7:0] r;
        repeat (3) @(negedge clk);
        // reset state (R4): general pins tri-stated, bit 2 output
        check("R4 reset oe", {4'h0, pin_oe}, 8'h04);
        check("R4 reset pu", {4'h0, pin_pu}, 8'h00);
        rst_n = 1'b1;
        @(negedge clk);
        rd(A_DIR, r);  check("R5 reset dir read", r, 8'h00);
        rd(A_DATA, r); check("R5 reset data read", r, 8'h00);

        // table walk: R1, R2, R3, R5
        for (int i = 0; i < 8; i++) begin
            logic [19:0] v;
            v = VEC[i];
            wr(A_DIR, {4'hF, v[19:16]});
            wr(A_DATA, {4'hF, v[15:12]});
            #0.5;
            check("R1/R2/R3 oe", {4'h0, pin_oe}, {4'h0, v[11:8]});
            check("R2/R3 pu", {4'h0, pin_pu}, {4'h0, v[7:4]});
            check("R1 driven out", {4'h0, pin_out & pin_oe & 4'b1011}, {4'h0, v[3:0]});
            rd(A_DIR, r);  check("R5 dir readback", r, {4'h0, v[19:16] & 4'b1011});
            rd(A_DATA, r); check("R5 data readback", r, {4'h0, v[15:12] & 4'b1011});
        end

        // R8: bit 2 follows led_mod regardless of direction
        wr(A_DIR, 8'h00);
        led_mod = 1'b0; #0.5;
        check("R8 led low", {7'h0, pin_out[2]}, 8'h00);
        check("R8 led oe", {6'h0, pin_oe[2], pin_pu[2]}, 8'h02);
        led_mod = 1'b1; #0.5;
        check("R8 led high", {7'h0, pin_out[2]}, 8'h01);

        // R6 with R5: pin read vs latch read, two-edge lag
        wr(A_DATA, 8'h00);
        pin_in = 4'b1111;
        @(negedge clk);
        rd(A_PIN, r); check("R6 one edge old", r, 8'h00);
        @(negedge clk);
        rd(A_PIN, r); check("R6 two edges new", r, 8'h0B);
        rd(A_DATA, r); check("R5 latch not pins", r, 8'h00);
        pin_in = 4'b0010;
        repeat (2) @(negedge clk);
        rd(A_PIN, r); check("R6 pattern 0010", r, 8'h02);

        // R7: writes to pin address ignored
        wr(A_DIR, 8'h01);
        wr(A_DATA, 8'h02);
        wr(A_PIN, 8'hFF);
        rd(A_DIR, r);  check("R7 dir kept", r, 8'h01);
        rd(A_DATA, r); check("R7 data kept", r, 8'h02);
        check("R7 pu kept", {4'h0, pin_pu}, 8'h02);

        // R9: other addresses ignored
        wr(8'h00, 8'hFF);
        wr(8'h1C, 8'hFF);
        wr(8'h18, 8'hFF);
        rd(A_DIR, r);  check("R9 dir kept", r, 8'h01);
        rd(A_DATA, r); check("R9 data kept", r, 8'h02);

        // R4: asynchronous reset, clock stopped, outputs driving
        wr(A_DIR, 8'h0B);
        wr(A_DATA, 8'h0B);
        check("R1 pre-reset oe", {4'h0, pin_oe}, 8'h0F);
        clk_run = 1'b0;
        #3 rst_n = 1'b0;
        #3;
        check("R4 async oe", {4'h0, pin_oe}, 8'h04);
        check("R4 async pu", {4'h0, pin_pu}, 8'h00);
        rst_n = 1'b1;
        clk_run = 1'b1;

        // R4: asynchronous reset drops pull-ups, clock stopped
        wr(A_DIR, 8'h00);
        wr(A_DATA, 8'h0B);
        check("R3 pre-reset pu", {4'h0, pin_pu}, 8'h0B);
        clk_run = 1'b0;
        #3 rst_n = 1'b0;
        #3;
        check("R4 async pu drop", {4'h0, pin_pu}, 8'h00);
        rst_n = 1'b1;
        clk_run = 1'b1;
        @(negedge clk);
        rd(A_DATA, r); check("R4 latch cleared", r, 8'h00);

        summary();
        $finish;
    end
endmodule